// File: doc/BRIEF.md
# Transmit Interrupt Acknowledge Sequencer

This block runs transmit interrupt service for a four-channel serial controller. Each channel raises a level request when its transmitter needs attention. The sequencer picks one requesting channel by fixed priority. It then pulls an active-low interrupt line to the host. When the host acknowledges, the sequencer releases the line and captures that channel's transmit status into a read-only byte. When the host writes end of interrupt, it clears the status byte and returns to idle.

The host sees the progress of each service episode as three flags: pending, active and end-of-interrupt. It gets two bytes for the episode:

- An acknowledge vector. Its upper bits come from a programmable base register, and hardware fills the low three bits with a transmit type code.
- A service identifier. It carries the same type code and the number of the channel being served.

Top module: `tx_irq_seq`

## Requirements
- R1: After reset the flags read 000, `irq_n` is 1, `tx_status` is 0x00 and `vector` is 0x02 (base register cleared).
- R2: The flags {pending, active, eoi} step 000 → 100 → 110 → 010 → 001 → 000. Each step is one clock edge, except that 110 waits for an acknowledge and 010 waits for end of interrupt.
- R3: `irq_n` is 0 exactly while the flags read 110. It is 1 again from the cycle after the edge that accepts `iack`.
- R4: When several channels request at once, the lowest-numbered channel is served. The served channel is latched on entry to 110 and does not change until end of interrupt, whatever the requests do in between.
- R5: `svc_id` bits 1:0 hold the served channel, bits 3:2 read binary 10, and bit 4 and above read 0.
- R6: `vector` bits 7:3 equal bits 7:3 of the last value written with `base_we`, and bits 2:0 read binary 010.
- R7: At the accepted acknowledge, `tx_status` takes the served channel's 7 flag bits, given as channel slice {bus error, end of frame, end of buffer, underrun, buffer A/B, tx empty, tx data}. These land at status bits 7, 6, 5, 4, 3, 1 and 0 in that order. Status bit 2 is always 0.
- R8: `tx_status` returns to 0x00 on the edge that accepts end of interrupt.
- R9: `iack` has no effect unless the flags read 110, and `eoi` has no effect unless they read 010. The flags and `tx_status` stay unchanged.
- R10: A request held through the 001 state is not served until the flags have returned to 000. The flags go 001 → 000 → 100.
- R11: If every request has gone away while the flags read 100, the sequencer returns to 000 without driving `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 4 | Per-channel transmit service request, level |
| ch_flags | input | 28 | Per-channel status flags, 7 bits per channel, channel n in bits 7n+6:7n |
| base_we | input | 1 | Write strobe for the vector base register |
| base_wdata | input | 8 | Vector base data; bits 7:3 are kept |
| iack | input | 1 | Host interrupt acknowledge strobe |
| eoi | input | 1 | Host end-of-interrupt strobe |
| irq_n | output | 1 | Active-low transmit interrupt to the host |
| flags | output | 3 | Episode flags {pending, active, eoi} |
| vector | output | 8 | Acknowledge vector byte |
| svc_id | output | 8 | Service identifier: type code and channel |
| tx_status | output | 8 | Captured transmit status byte |

## Verification
Full episodes are run from a table of request patterns:

- a single request on channel 0;
- two sparse requesters (1 and 3);
- channel 3 alone;
- the upper pair;
- all four channels at once.

Together these tell the priority order apart from "highest wins" and from "any fixed channel". Each channel's flag slice is filled with a different bit pattern, so a status taken from the wrong channel, or a bit placed in the wrong position, shows up as a wrong byte. Directed cases cover the following:

- requests changing after the latch;
- strobes given out of order;
- a request held across completion;
- a request withdrawn before assertion.

These separate the strict handshake from a design that takes a shortcut between states.

// File: rtl/tx_irq_pkg.sv
package tx_irq_pkg;

  // State encoding equals the host-visible {pending, active, eoi} flags.
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_PEND = 3'b100,
    ST_ASRT = 3'b110,
    ST_ACKD = 3'b010,
    ST_DONE = 3'b001
  } svc_state_e;

  localparam int unsigned CH_FLAG_W = 7;
  localparam logic [1:0]  TX_TYPE   = 2'b10;
  localparam logic [2:0]  VEC_LOW   = 3'b010;

endpackage

// File: rtl/tx_irq_rst_sync.sv
module tx_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tx_irq_prio.sv
module tx_irq_prio #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  output logic              any,
  output logic [CH_W-1:0]   pick
);

  // Walk from the top down so the lowest-numbered requester is the last write.
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick = CH_W'(i);
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/tx_irq_fsm.sv
module tx_irq_fsm
  import tx_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_req,
  input  logic       iack,
  input  logic       eoi,
  output svc_state_e state,
  output logic       latch_en,
  output logic       ack_fire,
  output logic       eoi_fire
);

  svc_state_e state_q, state_d;

  assign latch_en = (state_q == ST_PEND) && any_req;
  assign ack_fire = (state_q == ST_ASRT) && iack;
  assign eoi_fire = (state_q == ST_ACKD) && eoi;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (any_req) state_d = ST_PEND;
      ST_PEND: state_d = any_req ? ST_ASRT : ST_IDLE;
      ST_ASRT: if (iack) state_d = ST_ACKD;
      ST_ACKD: if (eoi) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/tx_irq_stat.sv
module tx_irq_stat
  import tx_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CH*CH_FLAG_W-1:0] ch_flags,
  input  logic [CH_W-1:0]             sel,
  input  logic                        cap_en,
  input  logic                        clr_en,
  output logic [7:0]                  status
);

  logic [CH_FLAG_W-1:0] slice [NUM_CH];
  logic [CH_FLAG_W-1:0] chosen;
  logic [7:0]           status_q, status_d;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slice
    assign slice[c] = ch_flags[c*CH_FLAG_W +: CH_FLAG_W];
  end

  always_comb begin
    chosen = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel == CH_W'(c)) begin
        chosen = slice[c];
      end
    end
  end

  always_comb begin
    status_d = status_q;
    if (clr_en) begin
      status_d = '0;
    end else if (cap_en) begin
      status_d = {chosen[6:2], 1'b0, chosen[1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (cap_en || clr_en) begin
      status_q <= status_d;
    end
  end

  assign status = status_q;

endmodule

// File: rtl/tx_irq_seq.sv
module tx_irq_seq
  import tx_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned VEC_W  = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned HW_W  = 3,
  localparam int unsigned FLG_W = NUM_CH * CH_FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tx_req,
  input  logic [FLG_W-1:0]  ch_flags,
  input  logic              base_we,
  input  logic [VEC_W-1:0]  base_wdata,
  input  logic              iack,
  input  logic              eoi,
  output logic              irq_n,
  output logic [2:0]        flags,
  output logic [VEC_W-1:0]  vector,
  output logic [7:0]        svc_id,
  output logic [7:0]        tx_status
);

  logic                    rst_q_n;
  logic                    any_req;
  logic [CH_W-1:0]         pick;
  svc_state_e              state;
  logic                    latch_en, ack_fire, eoi_fire;
  logic [CH_W-1:0]         ch_q, ch_d;
  logic [VEC_W-1:HW_W]     base_q, base_d;

  tx_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  tx_irq_prio #(.NUM_CH(NUM_CH)) u_prio (
    .req(tx_req), .any(any_req), .pick(pick)
  );

  tx_irq_fsm u_fsm (
    .clk(clk), .rst_n(rst_q_n), .any_req(any_req), .iack(iack), .eoi(eoi),
    .state(state), .latch_en(latch_en), .ack_fire(ack_fire), .eoi_fire(eoi_fire)
  );

  tx_irq_stat #(.NUM_CH(NUM_CH)) u_stat (
    .clk(clk), .rst_n(rst_q_n), .ch_flags(ch_flags), .sel(ch_q),
    .cap_en(ack_fire), .clr_en(eoi_fire), .status(tx_status)
  );

  // Served channel: frozen from the assert step until end of interrupt.
  always_comb begin
    ch_d = latch_en ? pick : ch_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ch_q <= '0;
    end else if (latch_en) begin
      ch_q <= ch_d;
    end
  end

  // Vector base: only the bits above the hardware-owned field are stored.
  always_comb begin
    base_d = base_we ? base_wdata[VEC_W-1:HW_W] : base_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      base_q <= '0;
    end else if (base_we) begin
      base_q <= base_d;
    end
  end

  assign flags  = state;
  assign irq_n  = (state != ST_ASRT);
  assign vector = {base_q, VEC_LOW};
  assign svc_id = 8'({TX_TYPE, ch_q});

endmodule

// File: rtl/tx_irq_seq_chk.sv
module tx_irq_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_n,
  input logic [2:0] flags,
  input logic [7:0] vector,
  input logic [7:0] svc_id,
  input logic [7:0] tx_status,
  input logic       base_we,
  input logic [7:0] base_wdata
);

  assert_pend_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 3'b100) |=> (flags == 3'b110 || flags == 3'b000));

  assert_asrt_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 3'b110) |=> (flags == 3'b110 || flags == 3'b010));

  assert_ackd_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 3'b010) |=> (flags == 3'b010 || flags == 3'b001));

  assert_done_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 3'b001) |=> (flags == 3'b000));

  assert_irq_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(flags) == 3'b100));

  assert_irq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> (flags == 3'b010));

  assert_chan_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags == 3'b010) && ($past(flags) == 3'b110)) |-> $stable(svc_id));

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags == 3'b001) && ($past(flags) == 3'b010)) |-> (tx_status == 8'h00));

  assert_base_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(base_we) |-> (vector[7:3] == $past(base_wdata[7:3])));

endmodule

bind tx_irq_seq tx_irq_seq_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .irq_n(irq_n), .flags(flags), .vector(vector),
  .svc_id(svc_id), .tx_status(tx_status), .base_we(base_we), .base_wdata(base_wdata)
);

// File: tb/tx_irq_seq_bench.sv
module tx_irq_seq_bench;

  logic        clk;
  logic        rst_n;
  logic [3:0]  tx_req;
  logic [27:0] ch_flags;
  logic        base_we;
  logic [7:0]  base_wdata;
  logic        iack;
  logic        eoi;
  logic        irq_n;
  logic [2:0]  flags;
  logic [7:0]  vector;
  logic [7:0]  svc_id;
  logic [7:0]  tx_status;

  int checks = 0;
  int errors = 0;

  tx_irq_seq u_tx_irq_seq (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .ch_flags(ch_flags),
    .base_we(base_we), .base_wdata(base_wdata), .iack(iack), .eoi(eoi),
    .irq_n(irq_n), .flags(flags), .vector(vector), .svc_id(svc_id),
    .tx_status(tx_status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Entry: {req[3:0], flags[27:0], expected channel[1:0], expected status[7:0]}
  localparam logic [41:0] EPISODES [5] = '{
    {4'b0001, 28'h000007F, 2'd0, 8'hFB},
    {4'b1010, 28'hFE02080, 2'd1, 8'h81},
    {4'b1000, 28'h4400000, 2'd3, 8'h42},
    {4'b1100, 28'hFE70000, 2'd2, 8'h38},
    {4'b1111, 28'hFFFFF80, 2'd0, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_req = '0; ch_flags = '0; base_we = 1'b0;
    base_wdata = '0; iack = 1'b0; eoi = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 flags", 8'(flags), 8'h00);
    chk("R1 irq_n", 8'(irq_n), 8'h01);
    chk("R1 status", tx_status, 8'h00);
    chk("R1 vector", vector, 8'h02);

    // R6 base register
    base_wdata = 8'hA5; base_we = 1'b1; step();
    base_we = 1'b0;
    chk("R6 vector", vector, 8'hA2);

    // Table of full episodes
    for (int k = 0; k < 5; k++) begin
      tx_req = EPISODES[k][41:38];
      ch_flags = EPISODES[k][37:10];
      step();
      chk("R2 pend", 8'(flags), 8'h04);
      chk("R3 irq high in pend", 8'(irq_n), 8'h01);
      step();
      chk("R2 asrt", 8'(flags), 8'h06);
      chk("R3 irq low", 8'(irq_n), 8'h00);
      chk("R4 R5 svc_id", svc_id, {6'b000010, EPISODES[k][9:8]});
      iack = 1'b1; step(); iack = 1'b0;
      chk("R2 ackd", 8'(flags), 8'h02);
      chk("R3 irq released", 8'(irq_n), 8'h01);
      chk("R7 status", tx_status, EPISODES[k][7:0]);
      tx_req = '0;
      eoi = 1'b1; step(); eoi = 1'b0;
      chk("R2 done", 8'(flags), 8'h01);
      chk("R8 status cleared", tx_status, 8'h00);
      step();
      chk("R2 idle", 8'(flags), 8'h00);
    end

    // R9 strobes ignored in idle
    iack = 1'b1; eoi = 1'b1; step(); iack = 1'b0; eoi = 1'b0;
    chk("R9 idle flags", 8'(flags), 8'h00);
    chk("R9 idle irq", 8'(irq_n), 8'h01);

    // R4 freeze, R9 wrong-phase strobes
    ch_flags = {7'h00, 7'h55, 7'h00, 7'h2A};
    tx_req = 4'b0100; step(); step();
    chk("R4 latched ch2", svc_id, 8'h0A);
    tx_req = 4'b0001;
    eoi = 1'b1; step(); eoi = 1'b0;
    chk("R9 eoi in asrt", 8'(flags), 8'h06);
    chk("R4 still ch2", svc_id, 8'h0A);
    iack = 1'b1; step(); iack = 1'b0;
    chk("R7 ch2 status", tx_status, 8'hA9);
    chk("R4 ch2 at ack", svc_id, 8'h0A);
    ch_flags = '1;
    iack = 1'b1; step(); iack = 1'b0;
    chk("R9 iack in ackd", 8'(flags), 8'h02);
    chk("R9 status kept", tx_status, 8'hA9);
    eoi = 1'b1; step(); eoi = 1'b0;
    chk("R2 done2", 8'(flags), 8'h01);
    // R10 request held through done
    step();
    chk("R10 idle first", 8'(flags), 8'h00);
    step();
    chk("R10 then pend", 8'(flags), 8'h04);
    chk("R4 new pick ch0", 8'(irq_n), 8'h01);
    step();
    chk("R4 ch0 svc_id", svc_id, 8'h08);
    iack = 1'b1; step(); iack = 1'b0;
    tx_req = '0;
    eoi = 1'b1; step(); eoi = 1'b0;
    step();
    chk("R2 idle again", 8'(flags), 8'h00);

    // R11 request withdrawn while pending
    tx_req = 4'b0010; step();
    chk("R11 pend", 8'(flags), 8'h04);
    tx_req = '0; step();
    chk("R11 back to idle", 8'(flags), 8'h00);
    chk("R11 irq never low", 8'(irq_n), 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule